// File: doc/BRIEF.md
# SDRAM Device Command Front-End

This block is the command side of a two-bank synchronous DRAM device model. At every rising clock edge it samples chip select, the row strobe, the column strobe, write enable, a bank select bit, an 11-bit multiplexed address and clock enable. It turns those pins into one of a small set of commands and keeps the state those commands change. That state is: which banks hold an open row, the row latched in each bank, the last column and its bank, and the mode register. The block has no storage array and no data path. A memory model or a protocol checker uses the registered outputs to find out what the device has just accepted and what mode it is in.

Clock enable gives two low-power behaviours. If any bank still has an open row when clock enable drops, the device suspends: its state is frozen and its pins are ignored until clock enable comes back. If both banks are idle, it enters power-down. Power-down also ignores the pins, but the device wakes on the very edge at which clock enable is seen high again and acts on the command present at that edge.

Top module: `sdram_cmd_front`

## Requirements
- R1: While chip select (`cs_n`) is high, the other command pins and the address are ignored. `acc_cmd` reads 0 on the next cycle, and no bank state, address register or mode register changes.
- R2: With `cs_n` low, the pins {ras_n,cas_n,we_n} are decoded as follows: 111 NOP, 011 activate, 101 read, 100 write, 010 precharge, 001 auto refresh, 000 mode write. The pattern 110 is treated as NOP. On the cycle after each accepted edge, `acc_cmd` reports the code of that command: 0 NOP, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh, 6 mode write. This holds even when the command is illegal. NOP and refresh change no state.
- R3: An activate to an idle bank marks that bank active and latches all 11 address bits as its row. Bank select 0 is bank A (`bank_active[0]`, `row_addr[10:0]`). Bank select 1 is bank B (`bank_active[1]`, `row_addr[21:11]`).
- R4: A read or write to an active bank latches `addr[7:0]` into `col_addr` and the bank select into `col_bank`.
- R5: A precharge with `addr[10]` high makes both banks idle. With `addr[10]` low, only the selected bank becomes idle.
- R6: A mode write while both banks are idle stores {ba, addr} into `mode_reg[11:0]`, with ba in bit 11. The new value is visible on the cycle after the edge. A mode write while any bank is active is refused and leaves `mode_reg` unchanged.
- R7: `illegal` is high for exactly the one cycle after an accepted command that is refused. A refused command is one of: an activate to an active bank, a read or write to an idle bank, or a refused mode write. A refused command changes no state.
- R8: The command at the edge where `cke` is first sampled low is still executed. If any bank is active after that edge, `suspended` rises. While suspended, the state is frozen and every edge is ignored, including the edge at which `cke` is seen high again. Commands are accepted again from the following edge.
- R9: If both banks are idle after the edge at which `cke` is first sampled low, `powered_down` rises. Edges with `cke` low are then ignored. The first edge with `cke` high leaves power-down and executes the command present at that edge.
- R10: After synchronous reset, both banks are idle and every register output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 1 | Bank select |
| addr | input | 11 | Multiplexed row/column/mode address; bit 10 selects all-bank precharge |
| bank_active | output | 2 | One bit per bank, 1 = row open |
| row_addr | output | 22 | Latched rows, bank A in the low 11 bits |
| col_addr | output | 8 | Last accepted column |
| col_bank | output | 1 | Bank of the last accepted column |
| mode_reg | output | 12 | Mode register, {ba, addr} |
| powered_down | output | 1 | Power-down state |
| suspended | output | 1 | Clock-suspend state |
| illegal | output | 1 | One-cycle flag for a refused command |
| acc_cmd | output | 3 | Code of the command accepted at the last edge |

## Verification
The hardest cases to reach are the two exits from the low-power states. They differ only in whether the waking edge is honoured, and which exit applies depends on the bank state at the moment `cke` falls. The stimulus builds both situations on purpose. It opens a bank, drops `cke` with a write at the same edge, and offers commands while suspended and at the resume edge. It then closes all banks, drops `cke` again, and offers an activate during power-down and another at the wake edge. A further case activates a bank at the same edge where `cke` falls, which must lead to suspend rather than power-down. A long pseudo-random stretch then mixes every pin, so that refused commands and low-power entries also arise in orders nobody planned.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    localparam int DEF_ADDR_W = 11;
    localparam int DEF_COL_W  = 8;
    localparam int DEF_BANK_W = 1;
    localparam int DEF_AP_BIT = 10;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5,
        CMD_MRS = 3'd6
    } cmd_e;

    typedef enum logic [1:0] {
        LP_RUN  = 2'd0,
        LP_SUSP = 2'd1,
        LP_PDN  = 2'd2
    } lp_e;

    function automatic cmd_e decode_pins(logic cs_n, logic ras_n, logic cas_n, logic we_n);
        cmd_e c;
        if (cs_n) begin
            c = CMD_NOP;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b011:  c = CMD_ACT;
                3'b101:  c = CMD_RD;
                3'b100:  c = CMD_WR;
                3'b010:  c = CMD_PRE;
                3'b001:  c = CMD_REF;
                3'b000:  c = CMD_MRS;
                default: c = CMD_NOP;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
    import sdcmd_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);
    always_comb cmd = decode_pins(cs_n, ras_n, cas_n, we_n);
endmodule

// File: rtl/sdcmd_lowpower.sv
module sdcmd_lowpower
    import sdcmd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cke,
    input  logic idle_next,
    output logic accept,
    output lp_e  state
);
    lp_e state_nxt;

    // Running edges are honoured; a power-down edge with cke high wakes and executes.
    always_comb accept = (state == LP_RUN) || ((state == LP_PDN) && cke);

    always_comb begin
        state_nxt = state;
        case (state)
            LP_RUN:  if (!cke) state_nxt = idle_next ? LP_PDN : LP_SUSP;
            LP_SUSP: if (cke)  state_nxt = LP_RUN;
            LP_PDN:  if (cke)  state_nxt = LP_RUN;
            default: state_nxt = LP_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= LP_RUN;
        else     state <= state_nxt;
    end
endmodule

// File: rtl/sdcmd_banks.sv
module sdcmd_banks #(
    parameter int ADDR_W = 11,
    parameter int COL_W  = 8,
    parameter int BANK_W = 1,
    localparam int NUM_BANKS = 1 << BANK_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        do_act,
    input  logic                        do_col,
    input  logic                        do_pre,
    input  logic                        pre_all,
    input  logic [BANK_W-1:0]           ba,
    input  logic [ADDR_W-1:0]           addr,
    output logic [NUM_BANKS-1:0]        active,
    output logic [NUM_BANKS-1:0]        active_nxt,
    output logic [NUM_BANKS*ADDR_W-1:0] rows,
    output logic [COL_W-1:0]            col,
    output logic [BANK_W-1:0]           col_bank
);
    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        logic              hit;
        logic [ADDR_W-1:0] row_q;

        always_comb begin
            hit = (ba == BANK_W'(i));
            active_nxt[i] = active[i];
            if (do_act && hit)              active_nxt[i] = 1'b1;
            if (do_pre && (pre_all || hit)) active_nxt[i] = 1'b0;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                active[i] <= 1'b0;
                row_q     <= '0;
            end else begin
                active[i] <= active_nxt[i];
                if (do_act && hit) row_q <= addr;
            end
        end

        assign rows[i*ADDR_W +: ADDR_W] = row_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            col      <= '0;
            col_bank <= '0;
        end else if (do_col) begin
            col      <= addr[COL_W-1:0];
            col_bank <= ba;
        end
    end
endmodule

// File: rtl/sdram_cmd_front.sv
module sdram_cmd_front
    import sdcmd_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int COL_W  = DEF_COL_W,
    parameter int BANK_W = DEF_BANK_W,
    parameter int AP_BIT = DEF_AP_BIT,
    localparam int NUM_BANKS = 1 << BANK_W,
    localparam int MODE_W    = ADDR_W + BANK_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cke,
    input  logic                        cs_n,
    input  logic                        ras_n,
    input  logic                        cas_n,
    input  logic                        we_n,
    input  logic [BANK_W-1:0]           ba,
    input  logic [ADDR_W-1:0]           addr,
    output logic [NUM_BANKS-1:0]        bank_active,
    output logic [NUM_BANKS*ADDR_W-1:0] row_addr,
    output logic [COL_W-1:0]            col_addr,
    output logic [BANK_W-1:0]           col_bank,
    output logic [MODE_W-1:0]           mode_reg,
    output logic                        powered_down,
    output logic                        suspended,
    output logic                        illegal,
    output logic [2:0]                  acc_cmd
);
    cmd_e                 cmd;
    logic                 accept;
    lp_e                  lp_state;
    logic [NUM_BANKS-1:0] active_nxt;
    logic                 sel_active, all_idle, bad;
    logic                 do_act, do_col, do_pre, do_mrs;
    cmd_e                 acc_q;
    logic                 ill_q;
    logic [MODE_W-1:0]    mode_q;

    sdcmd_decode u_dec (
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
    );

    sdcmd_lowpower u_lp (
        .clk(clk), .rst(rst), .cke(cke), .idle_next(~|active_nxt),
        .accept(accept), .state(lp_state)
    );

    always_comb begin
        sel_active = bank_active[ba];
        all_idle   = ~|bank_active;
        do_act = accept && (cmd == CMD_ACT) && !sel_active;
        do_col = accept && ((cmd == CMD_RD) || (cmd == CMD_WR)) && sel_active;
        do_pre = accept && (cmd == CMD_PRE);
        do_mrs = accept && (cmd == CMD_MRS) && all_idle;
        bad    = accept && (((cmd == CMD_ACT) && sel_active) ||
                            (((cmd == CMD_RD) || (cmd == CMD_WR)) && !sel_active) ||
                            ((cmd == CMD_MRS) && !all_idle));
    end

    sdcmd_banks #(.ADDR_W(ADDR_W), .COL_W(COL_W), .BANK_W(BANK_W)) u_banks (
        .clk(clk), .rst(rst),
        .do_act(do_act), .do_col(do_col), .do_pre(do_pre), .pre_all(addr[AP_BIT]),
        .ba(ba), .addr(addr),
        .active(bank_active), .active_nxt(active_nxt),
        .rows(row_addr), .col(col_addr), .col_bank(col_bank)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= CMD_NOP;
            ill_q  <= 1'b0;
            mode_q <= '0;
        end else begin
            acc_q <= accept ? cmd : CMD_NOP;
            ill_q <= bad;
            if (do_mrs) mode_q <= {ba, addr};
        end
    end

    assign acc_cmd      = acc_q;
    assign illegal      = ill_q;
    assign mode_reg     = mode_q;
    assign powered_down = (lp_state == LP_PDN);
    assign suspended    = (lp_state == LP_SUSP);
endmodule

// File: rtl/sdcmd_checker.sv
module sdcmd_checker #(
    parameter int NB = 2,
    parameter int RW = 22,
    parameter int CW = 8,
    parameter int MW = 12
) (
    input logic          clk,
    input logic          rst,
    input logic          cke,
    input logic          cs_n,
    input logic [NB-1:0] bank_active,
    input logic [RW-1:0] row_addr,
    input logic [CW-1:0] col_addr,
    input logic [MW-1:0] mode_reg,
    input logic          powered_down,
    input logic          suspended,
    input logic          illegal,
    input logic [2:0]    acc_cmd
);
    AST_DESEL_IGNORED: assert property (@(posedge clk) disable iff (rst)
        $past(cs_n) |-> (acc_cmd == 3'd0 && $stable(bank_active) && $stable(mode_reg))); // R1

    AST_ACT_OPENS: assert property (@(posedge clk) disable iff (rst)
        ((bank_active & ~$past(bank_active)) != '0) |-> (acc_cmd == 3'd1)); // R3

    AST_PRE_CLOSES: assert property (@(posedge clk) disable iff (rst)
        ((~bank_active & $past(bank_active)) != '0) |-> (acc_cmd == 3'd4)); // R5

    AST_MODE_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode_reg) |-> ($past(bank_active) == '0 && acc_cmd == 3'd6)); // R6

    AST_ILLEGAL_KIND: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (acc_cmd inside {3'd1, 3'd2, 3'd3, 3'd6})); // R7

    AST_SUSP_FROZEN: assert property (@(posedge clk) disable iff (rst)
        suspended |=> ($stable(bank_active) && $stable(row_addr) && $stable(col_addr) &&
                       $stable(mode_reg) && acc_cmd == 3'd0 && !illegal)); // R8

    AST_PD_IDLE: assert property (@(posedge clk) disable iff (rst)
        powered_down |-> (bank_active == '0)); // R9

    AST_PD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (powered_down && !cke) |=> (powered_down && acc_cmd == 3'd0)); // R9

    AST_LP_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(powered_down && suspended)); // R8
endmodule

bind sdram_cmd_front sdcmd_checker #(
    .NB(NUM_BANKS), .RW(NUM_BANKS*ADDR_W), .CW(COL_W), .MW(MODE_W)
) u_chk (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n),
    .bank_active(bank_active), .row_addr(row_addr), .col_addr(col_addr),
    .mode_reg(mode_reg), .powered_down(powered_down), .suspended(suspended),
    .illegal(illegal), .acc_cmd(acc_cmd)
);

// File: tb/sdram_cmd_front_test.sv
module sdram_cmd_front_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cke = 1'b1, cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic        ba = 1'b0;
    logic [10:0] addr = '0;
    logic [1:0]  bank_active;
    logic [21:0] row_addr;
    logic [7:0]  col_addr;
    logic        col_bank;
    logic [11:0] mode_reg;
    logic        powered_down, suspended, illegal;
    logic [2:0]  acc_cmd;

    int total = 0, fails = 0;
    bit done = 0;

    // reference model state
    bit          m_act [2];
    logic [10:0] m_row [2];
    logic [7:0]  m_col;
    bit          m_colb;
    logic [11:0] m_mode;
    int          m_lp;   // 0 run, 1 suspend, 2 power-down
    bit          m_ill;
    int          m_cmd;

    sdram_cmd_front uut (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .addr(addr), .bank_active(bank_active), .row_addr(row_addr),
        .col_addr(col_addr), .col_bank(col_bank), .mode_reg(mode_reg),
        .powered_down(powered_down), .suspended(suspended), .illegal(illegal),
        .acc_cmd(acc_cmd)
    );

    always #10 clk = ~clk;

    task automatic model_reset();
        m_act[0] = 0; m_act[1] = 0; m_row[0] = 0; m_row[1] = 0;
        m_col = 0; m_colb = 0; m_mode = 0; m_lp = 0; m_ill = 0; m_cmd = 0;
    endtask

    task automatic model_edge(bit k, bit c, bit r, bit a, bit w, bit b, logic [10:0] ad);
        bit take;
        int code;
        take = (m_lp == 0) || (m_lp == 2 && k);
        code = 0;
        if (take && !c) begin
            if      (!r &&  a &&  w) code = 1;
            else if ( r && !a &&  w) code = 2;
            else if ( r && !a && !w) code = 3;
            else if (!r &&  a && !w) code = 4;
            else if (!r && !a &&  w) code = 5;
            else if (!r && !a && !w) code = 6;
        end
        m_ill = 0;
        m_cmd = code;
        case (code)
            1: if (m_act[b]) m_ill = 1; else begin m_act[b] = 1; m_row[b] = ad; end
            2, 3: if (!m_act[b]) m_ill = 1; else begin m_col = ad[7:0]; m_colb = b; end
            4: if (ad[10]) begin m_act[0] = 0; m_act[1] = 0; end else m_act[b] = 0;
            6: if (m_act[0] || m_act[1]) m_ill = 1; else m_mode = {b, ad};
            default: ;
        endcase
        if (m_lp == 0) begin
            if (!k) m_lp = (!m_act[0] && !m_act[1]) ? 2 : 1;
        end else if (k) begin
            m_lp = 0;
        end
    endtask

    task automatic compare(string tag);
        logic [63:0] act, exp;
        act = {13'd0, bank_active, row_addr, col_addr, col_bank, mode_reg,
               powered_down, suspended, illegal, acc_cmd};
        exp = {13'd0, m_act[1], m_act[0], m_row[1], m_row[0], m_col, m_colb, m_mode,
               m_lp == 2, m_lp == 1, m_ill, 3'(m_cmd)};
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge after comparing
    task automatic step(string tag, bit k, bit c, bit r, bit a, bit w, bit b, logic [10:0] ad);
        cke = k; cs_n = c; ras_n = r; cas_n = a; we_n = w; ba = b; addr = ad;
        @(posedge clk);
        model_edge(k, c, r, a, w, b, ad);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        compare("R10");
        // deselect with mode-write and activate patterns underneath
        step("R1", 1, 1, 0, 0, 0, 1, 11'h7FF);
        step("R1", 1, 1, 0, 1, 1, 0, 11'h123);
        // NOP, refresh, reserved pattern
        step("R2", 1, 0, 1, 1, 1, 0, 11'h000);
        step("R2", 1, 0, 0, 0, 1, 0, 11'h000);
        step("R2", 1, 0, 1, 1, 0, 0, 11'h000);
        // activates on both banks
        step("R3", 1, 0, 0, 1, 1, 0, 11'h5A5);
        step("R3", 1, 0, 0, 1, 1, 1, 11'h2C3);
        // read bank A, write bank B
        step("R4", 1, 0, 1, 0, 1, 0, 11'h7F3);
        step("R4", 1, 0, 1, 0, 0, 1, 11'h41C);
        // refused commands
        step("R7", 1, 0, 0, 1, 1, 0, 11'h111);
        step("R6", 1, 0, 0, 0, 0, 0, 11'h022);
        // single-bank precharge, then read to now-idle bank
        step("R5", 1, 0, 0, 1, 0, 0, 11'h000);
        step("R7", 1, 0, 1, 0, 1, 0, 11'h0AA);
        step("R5", 1, 0, 0, 1, 0, 0, 11'h400);
        // mode write while idle, then observe hold
        step("R6", 1, 0, 0, 0, 0, 1, 11'h033);
        step("R6", 1, 0, 1, 1, 1, 0, 11'h000);
        // suspend: open bank, write at the cke-low edge
        step("R8", 1, 0, 0, 1, 1, 0, 11'h0F0);
        step("R8", 0, 0, 1, 0, 0, 0, 11'h0EE);
        step("R8", 0, 0, 0, 1, 1, 1, 11'h3FF);
        step("R8", 0, 0, 0, 1, 0, 0, 11'h400);
        step("R8", 1, 0, 0, 1, 0, 0, 11'h400);
        step("R8", 1, 0, 1, 0, 1, 0, 11'h055);
        // power-down: close all, drop cke, wake with activate
        step("R9", 1, 0, 0, 1, 0, 0, 11'h400);
        step("R9", 0, 0, 1, 1, 1, 0, 11'h000);
        step("R9", 0, 0, 0, 1, 1, 1, 11'h0C0);
        step("R9", 0, 0, 0, 0, 0, 0, 11'h0C0);
        step("R9", 1, 0, 0, 1, 1, 1, 11'h1B7);
        step("R9", 1, 0, 1, 1, 1, 0, 11'h000);
        // activate at the cke-low edge from idle leads to suspend
        step("R5", 1, 0, 0, 1, 0, 0, 11'h400);
        step("R8", 0, 0, 0, 1, 1, 0, 11'h321);
        step("R8", 1, 0, 1, 1, 1, 0, 11'h000);
        step("R8", 1, 0, 0, 1, 0, 0, 11'h400);
        // pseudo-random mix
        for (int i = 0; i < 400; i++) begin
            logic [15:0] v;
            v = 16'($urandom);
            step("R2", (v[3:0] != 0), (v[7:5] == 0), v[8], v[9], v[10], v[11],
                 {v[12], 10'($urandom)});
        end
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule